// File: doc/BRIEF.md
# Synchronous Bus Master with Wait States

This block lets a local requester start single transfers on a shared single-clock bus. The requester raises a request that carries a read/write flag, an operand size, an address, write data and a timeout limit. The master accepts it only when idle. It then drives the address and command on the bus from the first cycle onward. The transfer lasts as many cycles as the addressed slave needs, because the master waits for the slave's ready signal. On a read, it captures the bus read data on the edge where ready is sampled.

If no ready arrives within the limit taken with the request, the master gives up. It releases the bus and returns a one-cycle error pulse. A successful transfer ends with a one-cycle done pulse. Address decoding, arbitration and bursts belong to other blocks.

The state machine has five states: `ST_IDLE`, `ST_ADDR` (first bus cycle), `ST_WAIT` (later bus cycles), `ST_DONE` (done pulse) and `ST_ABORT` (error pulse). Its transitions are:
- accept: `ST_IDLE` to `ST_ADDR` when a request is present.
- hit: `ST_ADDR` or `ST_WAIT` to `ST_DONE` when the slave is ready.
- stall: `ST_ADDR` or `ST_WAIT` to `ST_WAIT` when there is no ready and the limit is not reached.
- expire: `ST_ADDR` or `ST_WAIT` to `ST_ABORT` when there is no ready in the last allowed cycle.
- retire: `ST_DONE` or `ST_ABORT` back to `ST_IDLE`.

Top module: `sbm_master`

## Requirements
- R1: During and right after reset the master is idle. `req_ready`=1, `bus_active`=0, `done_pulse`=0, `err_pulse`=0, and `rd_data`=0.
- R2: `req_ready` is 1 only in the idle state. A request with `req_valid`=1 in an idle cycle is accepted on that clock edge. In the very next cycle `bus_active`=1, `bus_addr`=the request address, `bus_rw`=the request flag (1 read, 0 write) and `bus_size`=the size code (0 byte, 1 halfword, 2 word).
- R3: `bus_wdata` carries the request write data during the bus cycles of a write, and is 0 during the bus cycles of a read.
- R4: From the first bus cycle until the transfer ends, address, command, size and write data stay unchanged. `req_ready` stays 0 and any request presented meanwhile is ignored.
- R5: If `bus_ack`=1 is sampled in bus cycle k (k=0 is the first), `done_pulse` is 1 for exactly one cycle, starting k+2 cycles after the accepting edge.
- R6: On a read, `rd_data` takes the `bus_rdata` value sampled with `bus_ack`. It is then held until the next successful read; writes and aborts leave it unchanged.
- R7: The limit L on `req_limit` is taken at acceptance. If no ready is seen in the first max(L,1) bus cycles, `err_pulse` is 1 for one cycle, starting max(L,1)+1 cycles after the accepting edge, and no done pulse follows.
- R8: In the done or error cycle and when idle, the bus is released: `bus_active`=0 and `bus_addr`, `bus_rw`, `bus_size` and `bus_wdata` are all 0.
- R9: `done_pulse` and `err_pulse` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester asks for a transfer |
| req_ready | output | 1 | Master idle, request will be taken |
| req_rd | input | 1 | 1 read, 0 write |
| req_size | input | 2 | Operand size code |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_limit | input | TW | Timeout limit in bus cycles |
| done_pulse | output | 1 | One-cycle success indication |
| err_pulse | output | 1 | One-cycle timeout indication |
| rd_data | output | DW | Last captured read data |
| bus_active | output | 1 | Address and command valid on the bus |
| bus_rw | output | 1 | Bus command, 1 read, 0 write |
| bus_size | output | 2 | Bus operand size |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Slave ready |
| bus_rdata | input | DW | Slave read data |

## Verification
The bus signals are due one cycle after the accepting edge. Done is due k+2 cycles after it when the slave answers in bus cycle k, and the error pulse is due max(L,1)+1 cycles after it. The driver task records the cycle number of the accepting edge and pushes the cycle in which each pulse must appear into the scoreboard. The monitor compares that cycle number with the counter when the pulse is seen. All inputs are driven and all outputs are sampled on the falling edge, half a period away from the edge on which the design updates.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_DONE,
        ST_ABORT
    } sbm_state_e;

    localparam int  SIZE_W    = 2;
    localparam logic CMD_READ = 1'b1;

endpackage

// File: rtl/sbm_timeout.sv
module sbm_timeout #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] limit_in,
    input  logic          active,
    output logic          expire
);
    logic [TW-1:0] lim_q;
    logic [TW-1:0] cnt_q;
    logic [TW:0]   next_cnt;

    assign next_cnt = {1'b0, cnt_q} + 1'b1;
    assign expire   = active && (next_cnt >= {1'b0, lim_q});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            lim_q <= limit_in;
            cnt_q <= '0;
        end else if (active && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: the wait count never passes the latched limit
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((cnt_q < lim_q) || (cnt_q == '0)));

endmodule

// File: rtl/sbm_fsm.sv
module sbm_fsm
    import sbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bus_ack,
    input  logic expire,
    output logic req_ready,
    output logic bus_active,
    output logic load_cmd,
    output logic capture,
    output logic done_pulse,
    output logic err_pulse
);
    sbm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ADDR;
            ST_ADDR,
            ST_WAIT: begin
                if (bus_ack)     state_d = ST_DONE;
                else if (expire) state_d = ST_ABORT;
                else             state_d = ST_WAIT;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        bus_active = 1'b0;
        load_cmd   = 1'b0;
        capture    = 1'b0;
        done_pulse = 1'b0;
        err_pulse  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                load_cmd  = req_valid;
            end
            ST_ADDR,
            ST_WAIT: begin
                bus_active = 1'b1;
                capture    = bus_ack;
            end
            ST_DONE:  done_pulse = 1'b1;
            ST_ABORT: err_pulse  = 1'b1;
            default: ;
        endcase
    end

    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && err_pulse));
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    assert_ack_to_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && bus_ack) |=> done_pulse);
    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
    assert_expire_to_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !bus_ack && expire) |=> (err_pulse && !bus_active));
    assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !bus_ack && !expire) |=> (bus_active && !req_ready));

endmodule

// File: rtl/sbm_datapath.sv
module sbm_datapath
    import sbm_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cmd,
    input  logic              req_rd,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              bus_active,
    input  logic              capture,
    input  logic [DW-1:0]     bus_rdata,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rw,
    output logic [SIZE_W-1:0] bus_size,
    output logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     rd_data
);
    logic [AW-1:0]     addr_q;
    logic              rw_q;
    logic [SIZE_W-1:0] size_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rw_q    <= 1'b0;
            size_q  <= '0;
            wdata_q <= '0;
        end else if (load_cmd) begin
            addr_q  <= req_addr;
            rw_q    <= req_rd;
            size_q  <= req_size;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            rd_q <= '0;
        else if (capture && rw_q == CMD_READ)  rd_q <= bus_rdata;
    end

    assign bus_addr  = bus_active ? addr_q : '0;
    assign bus_rw    = bus_active & rw_q;
    assign bus_size  = bus_active ? size_q : '0;
    assign bus_wdata = (bus_active && rw_q != CMD_READ) ? wdata_q : '0;
    assign rd_data   = rd_q;

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && $past(bus_active)) |->
        ($stable(bus_addr) && $stable(bus_rw) && $stable(bus_size) && $stable(bus_wdata)));
    assert_rd_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture && bus_rw) |=> $stable(rd_data));

endmodule

// File: rtl/sbm_master.sv
module sbm_master
    import sbm_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_rd,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [TW-1:0]     req_limit,
    output logic              done_pulse,
    output logic              err_pulse,
    output logic [DW-1:0]     rd_data,
    output logic              bus_active,
    output logic              bus_rw,
    output logic [SIZE_W-1:0] bus_size,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_ack,
    input  logic [DW-1:0]     bus_rdata
);
    logic load_cmd;
    logic capture;
    logic expire;

    sbm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .bus_ack    (bus_ack),
        .expire     (expire),
        .req_ready  (req_ready),
        .bus_active (bus_active),
        .load_cmd   (load_cmd),
        .capture    (capture),
        .done_pulse (done_pulse),
        .err_pulse  (err_pulse)
    );

    sbm_timeout #(.TW(TW)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cmd),
        .limit_in (req_limit),
        .active   (bus_active),
        .expire   (expire)
    );

    sbm_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cmd   (load_cmd),
        .req_rd     (req_rd),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bus_active (bus_active),
        .capture    (capture),
        .bus_rdata  (bus_rdata),
        .bus_addr   (bus_addr),
        .bus_rw     (bus_rw),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .rd_data    (rd_data)
    );

endmodule

// File: tb/sim_sbm_master.sv
`timescale 1ns/1ps
module sim_sbm_master;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_rd;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata;
    logic [7:0]  req_limit;
    logic        done_pulse, err_pulse;
    logic [31:0] rd_data;
    logic        bus_active, bus_rw;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    sbm_master u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rd(req_rd), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_limit(req_limit), .done_pulse(done_pulse),
        .err_pulse(err_pulse), .rd_data(rd_data), .bus_active(bus_active),
        .bus_rw(bus_rw), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    typedef struct {
        bit          is_err;
        logic [31:0] rd;
        int          due;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] last_rd = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a pulse appears
    always @(negedge clk) begin
        if (rst_n === 1'b1 && (done_pulse === 1'b1 || err_pulse === 1'b1)) begin
            if (sb.size() == 0) begin
                check("R5", "pulse with empty scoreboard", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check("R9", "pulses exclusive", 64'(done_pulse && err_pulse), 64'd0);
                check(e.is_err ? "R7" : "R5", "done level", 64'(done_pulse), 64'(!e.is_err));
                check("R7", "err level", 64'(err_pulse), 64'(e.is_err));
                check(e.is_err ? "R7" : "R5", "pulse cycle", 64'(cyc), 64'(e.due));
                check("R6", "rd_data", 64'(rd_data), 64'(e.rd));
            end
        end
    end

    // driver: one transfer, acting as the slave; dly < 0 means no answer
    task automatic run_txn(input bit rd, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] wd, input logic [7:0] lim, input int dly,
                           input logic [31:0] rdv, input bit poke);
        int   c;
        int   leff;
        int   k;
        exp_t e;
        @(negedge clk);
        check("R2", "ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_rd = rd; req_size = sz; req_addr = a;
        req_wdata = wd; req_limit = lim;
        c    = cyc;
        leff = (lim == 0) ? 1 : int'(lim);
        if (dly >= 0) begin
            e.is_err = 1'b0;
            e.rd     = rd ? rdv : last_rd;
            e.due    = c + 2 + dly;
            if (rd) last_rd = rdv;
        end else begin
            e.is_err = 1'b1;
            e.rd     = last_rd;
            e.due    = c + 1 + leff;
        end
        sb.push_back(e);
        @(negedge clk);
        k = 0;
        while (1) begin
            req_valid = 1'b0;
            req_addr  = a; req_rd = rd;
            check("R2", "bus_active", 64'(bus_active), 64'd1);
            check("R4", "bus_addr", 64'(bus_addr), 64'(a));
            check("R2", "bus_rw", 64'(bus_rw), 64'(rd));
            check("R2", "bus_size", 64'(bus_size), 64'(sz));
            check("R3", "bus_wdata", 64'(bus_wdata), rd ? 64'd0 : 64'(wd));
            check("R4", "ready low while busy", 64'(req_ready), 64'd0);
            if (poke && k == 1) begin
                req_valid = 1'b1; req_addr = ~a; req_rd = ~rd;
            end
            if (k == dly) begin
                bus_ack = 1'b1; bus_rdata = rdv;
                @(negedge clk);
                break;
            end
            if (dly < 0 && k == leff - 1) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
            k++;
        end
        bus_ack = 1'b0; bus_rdata = 32'hDEAD_BEEF; req_valid = 1'b0;
        check("R8", "released active", 64'(bus_active), 64'd0);
        check("R8", "released addr", 64'(bus_addr), 64'd0);
        check("R8", "released wdata", 64'(bus_wdata), 64'd0);
        check("R8", "released cmd", 64'({bus_rw, bus_size}), 64'd0);
        @(negedge clk);
        check("R2", "back to ready", 64'(req_ready), 64'd1);
        check("R8", "idle bus", 64'(bus_active), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_rd = 1'b0; req_size = '0;
        req_addr = '0; req_wdata = '0; req_limit = '0; bus_ack = 1'b0;
        bus_rdata = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        check("R1", "ready in reset", 64'(req_ready), 64'd1);
        check("R1", "bus idle in reset", 64'(bus_active), 64'd0);
        check("R1", "no pulses in reset", 64'({done_pulse, err_pulse}), 64'd0);
        check("R1", "rd_data in reset", 64'(rd_data), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", 64'({req_ready, bus_active}), 64'b10);
        run_txn(1'b0, 2'd2, 32'h0000_1000, 32'h1122_3344, 8'd8,   0, 32'h5555_0000, 1'b0);
        run_txn(1'b1, 2'd0, 32'h0000_1001, 32'h0,         8'd8,   3, 32'h0000_00A5, 1'b0);
        run_txn(1'b1, 2'd1, 32'h0000_2002, 32'h0,         8'd5,   4, 32'h0000_BEEF, 1'b0);
        run_txn(1'b1, 2'd2, 32'h0000_3000, 32'h0,         8'd5,  -1, 32'h0,         1'b1);
        run_txn(1'b1, 2'd2, 32'h0000_3004, 32'h0,         8'd0,  -1, 32'h0,         1'b0);
        run_txn(1'b1, 2'd2, 32'h0000_4000, 32'h0,         8'd1,   0, 32'h1234_5678, 1'b0);
        run_txn(1'b0, 2'd1, 32'h0000_5002, 32'h0000_CAFE, 8'd6,   2, 32'h7777_7777, 1'b1);
        run_txn(1'b1, 2'd2, 32'h0000_6000, 32'h0,         8'd255, 20, 32'h0BAD_F00D, 1'b0);
        repeat (2) @(negedge clk);
        check("R5", "all pulses seen", 64'(sb.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule